// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds off all traffic for a power-up pause. It then runs eight wake-up refresh cycles and only after that raises `ready_o`. From then on it spreads refreshes evenly, so that every row is refreshed once per retention period. The refresh interval is the retention period times the clock rate, divided by the row count.

The block shares the DRAM pins with an access controller through a request/grant handshake. It raises `ref_req_o` and waits for `ref_gnt_i`. While it owns the bus (`strobe_own_o`), it drives RAS and both CAS strobes itself. The default refresh is CAS-before-RAS, where the DRAM supplies the row itself. When `ras_only_i` is high, the block instead pulses RAS with both CAS lines high and places the row from its own counter on `addr_o`.

Refreshes that cannot be issued because the grant is withheld are queued, up to `MAX_PEND` of them. Once the grant arrives they are issued back to back. If a further interval expires while the queue is full, the retention guarantee is lost. The block then sets a sticky overflow flag, drops `ready_o` and reruns the eight wake-up refreshes. All durations are given in microseconds or nanoseconds and converted to cycles from `CLK_MHZ`.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `casl_n_o` and `cash_n_o` are high, and `ref_req_o`, `strobe_own_o`, `ready_o` and `overflow_o` are low.
- R2: After reset is released, `ref_req_o` stays low and `ready_o` stays low for PAUSE_US*CLK_MHZ cycles (the pause); the request rises within one cycle after that.
- R3: After the pause exactly WAKE_REFRESHES (8) refresh cycles are issued before `ready_o` rises; `ready_o` stays low during them.
- R4: In a CAS-before-RAS refresh both CAS lines are low for exactly ceil(T_CSR_NS*CLK_MHZ/1000) cycles before RAS falls. RAS is low for ceil(T_RAS_NS*CLK_MHZ/1000) cycles. CAS stays low for the first ceil(T_CHR_NS*CLK_MHZ/1000) of those cycles, then all strobes return high.
- R5: RAS stays high for at least ceil(T_RP_NS*CLK_MHZ/1000) cycles between two refreshes.
- R6: Once ready and with an immediate grant, successive RAS falling edges are exactly RETENTION_US*CLK_MHZ/ROWS cycles apart.
- R7: Strobes go low and `strobe_own_o` is high only while `ref_gnt_i` is high. With no grant, no refresh starts and `ref_req_o` stays high while work is pending.
- R8: Refreshes deferred by a withheld grant (up to MAX_PEND) are all issued back to back once the grant returns, without overflow and without dropping `ready_o`.
- R9: An interval that expires with MAX_PEND refreshes already queued sets `overflow_o` (sticky until reset), drops `ready_o` and reruns eight refreshes before `ready_o` rises again.
- R10: With `ras_only_i` high, CAS lines stay high through the refresh and `addr_o` at each RAS fall is the previous row plus one, wrapping from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | 1: row-addressed refresh from internal counter; 0: CAS-before-RAS |
| ref_gnt_i | input | 1 | Bus grant from the access controller |
| ref_req_o | output | 1 | Refresh request to the access controller |
| strobe_own_o | output | 1 | Block is driving the strobes this cycle |
| ready_o | output | 1 | Wake-up done; normal accesses allowed |
| overflow_o | output | 1 | Sticky: a refresh interval was missed |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Lower column strobe, active low |
| cash_n_o | output | 1 | Upper column strobe, active low |
| addr_o | output | ROW_W | Row address in row-addressed mode |

## Verification
`ref_req_o` rises one cycle after the pause or a pacing tick ends. The strobes start changing one cycle after the grant is sampled. RAS falls T_CSR cycles after CAS in CAS-before-RAS mode. `ready_o` rises in the cycle after the last wake-up precharge ends. The bench samples every output on the falling clock edge. It measures pulse widths and edge spacings by counting those samples, so exact widths and the pacing interval are compared cycle for cycle. Windows that depend on where the pacing timer stands (queued backlog, overflow) are sized with half an interval of margin on each side, so the expected number of ticks is fixed.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } ref_phase_e;

  typedef enum logic [1:0] {
    SG_IDLE   = 2'd0,
    SG_SETUP  = 2'd1,
    SG_ACTIVE = 2'd2,
    SG_PRECH  = 2'd3
  } strobe_st_e;

  // round up, never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/ref_phase_ctrl.sv
module ref_phase_ctrl
  import dram_ref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 25000,
  parameter int unsigned WAKE_N    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       miss_i,
  output ref_phase_e phase_o
);

  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WAKE_N + 1);

  ref_phase_e    ph_q;
  logic [PW-1:0] pause_q;
  logic [WW-1:0] wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_PAUSE;
      pause_q <= PW'(PAUSE_CYC - 1);
      wake_q  <= WW'(WAKE_N);
    end else begin
      unique case (ph_q)
        PH_PAUSE: begin
          if (pause_q == '0) ph_q <= PH_WAKE;
          else               pause_q <= pause_q - 1'b1;
        end
        PH_WAKE: begin
          if (done_i) begin
            if (wake_q == WW'(1)) ph_q <= PH_RUN;
            wake_q <= wake_q - 1'b1;
          end
        end
        PH_RUN: begin
          // lost retention: redo the wake-up burst
          if (miss_i) begin
            ph_q   <= PH_WAKE;
            wake_q <= WW'(WAKE_N);
          end
        end
        default: ph_q <= PH_PAUSE;
      endcase
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/ref_pacer.sv
module ref_pacer #(
  parameter int unsigned INTERVAL_CYC = 1953,
  parameter int unsigned MAX_PEND     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic pend_o,
  output logic miss_o
);

  localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned QW = $clog2(MAX_PEND + 1);

  logic [TW-1:0] timer_q;
  logic [QW-1:0] pend_q;
  logic          tick, full, dn;

  assign tick   = run_i && (timer_q == '0);
  assign dn     = run_i && done_i;
  assign full   = (pend_q == QW'(MAX_PEND));
  assign miss_o = tick && full && !dn;
  assign pend_o = (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= TW'(INTERVAL_CYC - 1);
      pend_q  <= '0;
    end else if (!run_i) begin
      timer_q <= TW'(INTERVAL_CYC - 1);
      pend_q  <= '0;
    end else begin
      timer_q <= tick ? TW'(INTERVAL_CYC - 1) : timer_q - 1'b1;
      if (tick && !dn && !full)           pend_q <= pend_q + 1'b1;
      else if (!tick && dn && pend_o)     pend_q <= pend_q - 1'b1;
    end
  end

endmodule

// File: rtl/ref_strobe_gen.sv
module ref_strobe_gen
  import dram_ref_pkg::*;
#(
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned RAS_CYC      = 8,
  parameter int unsigned RP_CYC       = 5,
  parameter int unsigned ROWS         = 512,
  parameter bit          HAS_RAS_ONLY = 1'b1,
  localparam int unsigned ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             ras_only_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int unsigned MAX_AB = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int unsigned MAXC   = (MAX_AB > RP_CYC) ? MAX_AB : RP_CYC;
  localparam int unsigned CNT_W  = $clog2(MAXC + 1);
  localparam int unsigned CHR_E  = (CHR_CYC > RAS_CYC) ? RAS_CYC : CHR_CYC;

  strobe_st_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;
  logic             mode_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SG_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (st_q)
        SG_IDLE: if (go_i) begin
          mode_q <= mode_sel;
          if (mode_sel) begin
            st_q  <= SG_ACTIVE;
            cnt_q <= CNT_W'(RAS_CYC - 1);
          end else begin
            st_q  <= SG_SETUP;
            cnt_q <= CNT_W'(CSR_CYC - 1);
          end
        end
        SG_SETUP: begin
          if (cnt_q == '0) begin
            st_q  <= SG_ACTIVE;
            cnt_q <= CNT_W'(RAS_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        SG_ACTIVE: begin
          if (cnt_q == '0) begin
            st_q  <= SG_PRECH;
            cnt_q <= CNT_W'(RP_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        SG_PRECH: begin
          if (cnt_q == '0) st_q <= SG_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SG_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SG_IDLE);
  assign done_o  = (st_q == SG_PRECH) && (cnt_q == '0);
  assign ras_n_o = (st_q != SG_ACTIVE);
  // CAS low through setup and the first CHR cycles of the RAS pulse
  assign cas_n_o = !(!mode_q && ((st_q == SG_SETUP) ||
                    ((st_q == SG_ACTIVE) && (cnt_q >= CNT_W'(RAS_CYC - CHR_E)))));

  if (HAS_RAS_ONLY) begin : g_row
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               row_q <= '0;
      else if (done_o && mode_q) row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
    assign row_o    = row_q;
    assign mode_sel = ras_only_i;
  end else begin : g_no_row
    assign row_o    = '0;
    assign mode_sel = ras_only_i & 1'b0;
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ        = 125,
  parameter int unsigned PAUSE_US       = 200,
  parameter int unsigned RETENTION_US   = 8000,
  parameter int unsigned ROWS           = 512,
  parameter int unsigned WAKE_REFRESHES = 8,
  parameter int unsigned MAX_PEND       = 4,
  parameter int unsigned T_CSR_NS       = 10,
  parameter int unsigned T_CHR_NS       = 10,
  parameter int unsigned T_RAS_NS       = 60,
  parameter int unsigned T_RP_NS        = 40,
  parameter bit          HAS_RAS_ONLY   = 1'b1,
  localparam int unsigned ROW_W         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             strobe_own_o,
  output logic             ready_o,
  output logic             overflow_o,
  output logic             ras_n_o,
  output logic             casl_n_o,
  output logic             cash_n_o,
  output logic [ROW_W-1:0] addr_o
);

  localparam int unsigned PAUSE_CYC    = PAUSE_US * CLK_MHZ;
  localparam int unsigned INTERVAL_CYC = RETENTION_US * CLK_MHZ / ROWS;
  localparam int unsigned CSR_CYC      = ns_to_cycles(T_CSR_NS, CLK_MHZ);
  localparam int unsigned CHR_CYC      = ns_to_cycles(T_CHR_NS, CLK_MHZ);
  localparam int unsigned RAS_CYC      = ns_to_cycles(T_RAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC       = ns_to_cycles(T_RP_NS, CLK_MHZ);

  ref_phase_e phase;
  logic       run, pend, miss, need, go, busy, done, cas_n, ovf_q;

  ref_phase_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_N    (WAKE_REFRESHES)
  ) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .miss_i  (miss),
    .phase_o (phase)
  );

  assign run = (phase == PH_RUN);

  ref_pacer #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .MAX_PEND     (MAX_PEND)
  ) i_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .done_i (done),
    .pend_o (pend),
    .miss_o (miss)
  );

  assign need = (phase == PH_WAKE) || (run && pend);
  assign go   = need && ref_gnt_i;

  ref_strobe_gen #(
    .CSR_CYC      (CSR_CYC),
    .CHR_CYC      (CHR_CYC),
    .RAS_CYC      (RAS_CYC),
    .RP_CYC       (RP_CYC),
    .ROWS         (ROWS),
    .HAS_RAS_ONLY (HAS_RAS_ONLY)
  ) i_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .ras_only_i (ras_only_i),
    .busy_o     (busy),
    .done_o     (done),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n),
    .row_o      (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (miss) ovf_q <= 1'b1;
  end

  assign ref_req_o    = need || busy;
  assign strobe_own_o = busy;
  assign ready_o      = run;
  assign overflow_o   = ovf_q;
  assign casl_n_o     = cas_n;
  assign cash_n_o     = cas_n;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned RAS_CYC = 8,
  parameter int unsigned RP_CYC  = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_only_i,
  input logic ref_gnt_i,
  input logic ref_req_o,
  input logic ready_o,
  input logic overflow_o,
  input logic ras_n_o,
  input logic casl_n_o,
  input logic cash_n_o
);

  localparam int unsigned LW = $clog2(RAS_CYC + 2);
  localparam int unsigned HW = $clog2(RP_CYC + 2);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= HW'(RP_CYC);
    end else begin
      if (ras_n_o) lo_cnt <= '0;
      else if (lo_cnt != LW'(RAS_CYC)) lo_cnt <= lo_cnt + 1'b1;
      if (!ras_n_o) hi_cnt <= '0;
      else if (hi_cnt != HW'(RP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_cbr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !ras_only_i) |-> ($past(!casl_n_o && !cash_n_o) && !casl_n_o && !cash_n_o));

  assert_ras_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt >= LW'(RAS_CYC)));

  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= HW'(RP_CYC)));

  assert_strobe_granted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !casl_n_o || !cash_n_o) |-> ref_gnt_i);

  assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> ref_req_o);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overflow_o) |-> overflow_o);

  assert_ovf_drops_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> !ready_o);

  assert_row_mode_cas_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && ras_only_i) |-> (casl_n_o && cash_n_o));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC (RAS_CYC),
  .RP_CYC  (RP_CYC)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_only_i (ras_only_i),
  .ref_gnt_i  (ref_gnt_i),
  .ref_req_o  (ref_req_o),
  .ready_o    (ready_o),
  .overflow_o (overflow_o),
  .ras_n_o    (ras_n_o),
  .casl_n_o   (casl_n_o),
  .cash_n_o   (cash_n_o)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;

  localparam int unsigned MHZ   = 125;
  localparam int unsigned P_US  = 2;
  localparam int unsigned RET   = 32;
  localparam int unsigned NROWS = 16;
  localparam int unsigned MAXP  = 4;
  localparam int unsigned RW    = 4;

  localparam int E_PAUSE = P_US * MHZ;
  localparam int E_INT   = RET * MHZ / NROWS;
  localparam int E_CSR   = (10 * MHZ + 999) / 1000;
  localparam int E_CHR   = (10 * MHZ + 999) / 1000;
  localparam int E_RAS   = (60 * MHZ + 999) / 1000;
  localparam int E_RP    = (40 * MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_only_i = 1'b0;
  logic ref_gnt_i = 1'b0;
  logic ref_req_o, strobe_own_o, ready_o, overflow_o, ras_n_o, casl_n_o, cash_n_o;
  logic [RW-1:0] addr_o;

  dram_refresh_seq #(
    .CLK_MHZ      (MHZ),
    .PAUSE_US     (P_US),
    .RETENTION_US (RET),
    .ROWS         (NROWS),
    .MAX_PEND     (MAXP)
  ) i_dram_refresh_seq (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ras_only_i   (ras_only_i),
    .ref_gnt_i    (ref_gnt_i),
    .ref_req_o    (ref_req_o),
    .strobe_own_o (strobe_own_o),
    .ready_o      (ready_o),
    .overflow_o   (overflow_o),
    .ras_n_o      (ras_n_o),
    .casl_n_o     (casl_n_o),
    .cash_n_o     (cash_n_o),
    .addr_o       (addr_o)
  );

  initial forever #4 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  gnt_en = 1'b1;
  bit  finished = 1'b0;

  // monitor state
  int  cyc = 0, n_ref = 0;
  int  falls [256];
  int  ras_lo_run = 0, cas_pre_run = 0, chr_run = 0, rp_run = 0;
  bit  prev_r = 1'b1, rp_valid = 1'b0, have_row = 1'b0;
  int  prev_row = 0;
  int  bad_csr = 0, bad_ras = 0, bad_chr = 0, bad_rp = 0, bad_ro = 0;
  int  bad_step = 0, wraps = 0, bad_gnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // grant driver: follows request half a cycle later when enabled
  initial forever begin
    @(negedge clk);
    #1 ref_gnt_i = gnt_en && ref_req_o;
  end

  // strobe monitor, sampled on falling edge
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      bit c_lo, c_any;
      cyc++;
      c_lo  = !casl_n_o && !cash_n_o;
      c_any = !casl_n_o || !cash_n_o;
      if ((!ras_n_o || c_any) && !ref_gnt_i) bad_gnt++;
      if (!ras_n_o) begin
        if (prev_r) begin
          n_ref++;
          falls[n_ref % 256] = cyc;
          if (!ras_only_i) begin
            if (cas_pre_run != E_CSR) bad_csr++;
            have_row = 1'b0;
          end else begin
            if (c_any || cas_pre_run != 0) bad_ro++;
            if (have_row) begin
              if (int'(addr_o) != (prev_row + 1) % NROWS) bad_step++;
              if (addr_o == '0) wraps++;
            end
            prev_row = int'(addr_o);
            have_row = 1'b1;
          end
          if (rp_valid && rp_run < E_RP) bad_rp++;
          ras_lo_run = 1;
          chr_run = c_lo ? 1 : 0;
        end else begin
          ras_lo_run++;
          if (c_lo) chr_run++;
          if (ras_only_i && c_any) bad_ro++;
        end
      end else begin
        if (!prev_r) begin
          if (ras_lo_run != E_RAS) bad_ras++;
          if (!ras_only_i && chr_run != E_CHR) bad_chr++;
          rp_run = 1;
          rp_valid = 1'b1;
        end else rp_run++;
        cas_pre_run = c_lo ? cas_pre_run + 1 : 0;
      end
      prev_r = ras_n_o;
    end
  end

  task automatic wait_req_low();
    for (int i = 0; i < 4 * E_INT && ref_req_o; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ras_n_o == 1'b1, "R1 ras_n", ras_n_o, 1);
    chk(casl_n_o && cash_n_o, "R1 cas_n", casl_n_o & cash_n_o, 1);
    chk(ref_req_o == 1'b0, "R1 req", ref_req_o, 0);
    chk(strobe_own_o == 1'b0, "R1 own", strobe_own_o, 0);
    chk(ready_o == 1'b0, "R1 ready", ready_o, 0);
    chk(overflow_o == 1'b0, "R1 overflow", overflow_o, 0);
  endtask

  task automatic t_powerup();
    int cnt = 0, early = 0;
    rst_ni = 1'b1;
    while (!ref_req_o && cnt < 3 * E_PAUSE) begin
      @(negedge clk);
      cnt++;
      if (ready_o) early++;
    end
    chk(cnt >= E_PAUSE && cnt <= E_PAUSE + 1, "R2 pause length", cnt, E_PAUSE);
    chk(early == 0, "R2 ready during pause", early, 0);
    for (int i = 0; i < 40 * E_RAS && !ready_o; i++) @(negedge clk);
    chk(ready_o == 1'b1, "R3 ready after wake", ready_o, 1);
    chk(n_ref == 8, "R3 wake refresh count", n_ref, 8);
    chk(bad_csr == 0, "R4 cas setup", bad_csr, 0);
    chk(bad_ras == 0, "R4 ras width", bad_ras, 0);
    chk(bad_chr == 0, "R4 cas hold", bad_chr, 0);
  endtask

  task automatic t_periodic();
    int base, bad = 0, sp = 0;
    base = n_ref;
    for (int i = 0; i < 7 * E_INT && n_ref < base + 5; i++) @(negedge clk);
    chk(n_ref == base + 5, "R6 refreshes issued", n_ref - base, 5);
    for (int k = base + 2; k <= base + 5; k++) begin
      sp = falls[k % 256] - falls[(k - 1) % 256];
      if (sp != E_INT) bad++;
    end
    chk(bad == 0, "R6 interval spacing", sp, E_INT);
    chk(bad_rp == 0, "R5 precharge", bad_rp, 0);
    chk(ready_o == 1'b1, "R6 ready held", ready_o, 1);
  endtask

  task automatic t_backlog();
    int b, sp;
    wait_req_low();
    gnt_en = 1'b0;
    b = n_ref;
    repeat (3 * E_INT + E_INT / 2 - 16) @(negedge clk);
    chk(n_ref == b, "R7 no refresh without grant", n_ref - b, 0);
    chk(ref_req_o == 1'b1, "R7 request held", ref_req_o, 1);
    chk(strobe_own_o == 1'b0, "R7 not owning", strobe_own_o, 0);
    gnt_en = 1'b1;
    repeat (E_INT / 4) @(negedge clk);
    chk(n_ref - b == 3, "R8 burst count", n_ref - b, 3);
    sp = falls[n_ref % 256] - falls[(n_ref - 1) % 256];
    chk(sp < E_INT / 4, "R8 back to back", sp, E_CSR + E_RAS + E_RP + 1);
    chk(overflow_o == 1'b0, "R8 no overflow", overflow_o, 0);
    chk(ready_o == 1'b1, "R8 ready kept", ready_o, 1);
    chk(bad_gnt == 0, "R7 strobe without grant", bad_gnt, 0);
  endtask

  task automatic t_overflow();
    int b;
    wait_req_low();
    gnt_en = 1'b0;
    b = n_ref;
    repeat (6 * E_INT) @(negedge clk);
    chk(overflow_o == 1'b1, "R9 overflow set", overflow_o, 1);
    chk(ready_o == 1'b0, "R9 ready dropped", ready_o, 0);
    chk(n_ref == b, "R9 no refresh while blocked", n_ref - b, 0);
    gnt_en = 1'b1;
    for (int i = 0; i < 2 * E_INT && !ready_o; i++) @(negedge clk);
    chk(ready_o == 1'b1, "R9 ready regained", ready_o, 1);
    chk(n_ref - b == 8, "R9 wake rerun count", n_ref - b, 8);
    chk(overflow_o == 1'b1, "R9 overflow sticky", overflow_o, 1);
  endtask

  task automatic t_rasonly();
    int b;
    wait_req_low();
    ras_only_i = 1'b1;
    b = n_ref;
    for (int i = 0; i < (NROWS + 4) * E_INT && n_ref < b + NROWS + 2; i++) @(negedge clk);
    chk(n_ref - b == NROWS + 2, "R10 refreshes issued", n_ref - b, NROWS + 2);
    chk(bad_ro == 0, "R10 cas stays high", bad_ro, 0);
    chk(bad_step == 0, "R10 row step", bad_step, 0);
    chk(wraps >= 1, "R10 row wrap", wraps, 1);
    chk(bad_ras == 0, "R4 ras width row mode", bad_ras, 0);
    wait_req_low();
    ras_only_i = 1'b0;
    b = n_ref;
    for (int i = 0; i < 2 * E_INT && n_ref < b + 2; i++) @(negedge clk);
    chk(bad_csr == 0 && bad_chr == 0, "R4 cbr after row mode", bad_csr + bad_chr, 0);
    chk(bad_rp == 0, "R5 precharge overall", bad_rp, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_periodic();
    t_backlog();
    t_overflow();
    t_rasonly();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule